// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block builds one byte-wide memory out of eight equal banks that share a single 20-bit address bus. Each address is split into a bank number and an offset inside that bank. A one-bit mode input chooses how the split is made. In contiguous mode the high-order bits choose the bank. In interleaved mode the low-order bits choose the bank, so neighbouring addresses land in neighbouring banks.

The block drives one active-low chip select per bank and a shared active-low write enable. The bank decoder is gated by the command lines, so no bank is selected unless exactly one of read or write is asserted. Asserting both at once is reported as a conflict, and neither operation takes place.

Each bank is held internally as a small register array whose depth is a parameter, and only the low bits of the in-bank offset address it. The shared bidirectional data bus is modelled as a separate write-data input, a read-data output and an output-enable. Read data comes out registered, one clock after the read command.

Top module: `banked_mem_decoder`

## Requirements
- R1: In contiguous mode (`ilv_i`=0) the bank number is `addr_i[19:17]` and the offset is `addr_i[16:0]`. During a lone read or write, exactly one chip select is low: `cs_no[n]` for bank n.
- R2: In interleaved mode (`ilv_i`=1) the bank number is `addr_i[2:0]` and the offset is `addr_i[19:3]`. As a result, addresses 0..7 select banks 0..7 in turn.
- R3: Storage inside a bank is addressed by the offset modulo BANK_DEPTH (default 16). Offsets that differ only above those low bits share one byte.
- R4: When neither `rd_i` nor `wr_i` is high, all `cs_no` bits are 1 and `we_no` is 1.
- R5: A lone write drives `we_no` low and the addressed `cs_no` bit low in the same cycle. The byte on `wdata_i` is stored at the next rising clock edge.
- R6: A lone read keeps `we_no` high. At the rising edge that follows, `rdata_o` carries the stored byte, with `rdata_vld_o` and `data_oe_o` both 1 for that one cycle. At all other times these two outputs are 0 and `rdata_o` is 0.
- R7: When `rd_i` and `wr_i` are both high, `conflict_o` is 1, every chip select stays high, `we_no` stays high, nothing is stored and no read data is returned.
- R8: A write changes only the selected bank. The same offset in every other bank keeps its value, and at most one bank drives read data at a time.
- R9: After reset `rdata_vld_o` and `data_oe_o` are 0, `rdata_o` is 0, and every stored byte reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Byte address |
| ilv_i | input | 1 | Split mode: 0 contiguous, 1 interleaved |
| rd_i | input | 1 | Read command |
| wr_i | input | 1 | Write command |
| wdata_i | input | 8 | Write data (inbound half of data bus) |
| cs_no | output | 8 | Active-low per-bank chip selects |
| we_no | output | 1 | Shared active-low write enable |
| conflict_o | output | 1 | Read and write asserted together |
| rdata_o | output | 8 | Read data (outbound half of data bus) |
| rdata_vld_o | output | 1 | Read data valid |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
Chip selects, write enable and the conflict flag depend only on the present inputs. The driver therefore checks them 1 ns after it changes the inputs on the falling edge, within the same cycle. A stored byte first becomes visible through a read issued in a later cycle. Read data is due exactly one rising edge after the read command. The monitor samples 1 ns after every rising edge, so it expects valid data in the cycle right after each queued read and flags both missing returns and unrequested ones.

// File: rtl/bank_pkg.sv
package bank_pkg;
  typedef enum logic {
    SPLIT_CONTIG = 1'b0,
    SPLIT_ILV    = 1'b1
  } split_mode_e;
endpackage

// File: rtl/addr_split.sv
module addr_split
  import bank_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BANK_BITS  = 3,
  parameter int BANK_DEPTH = 16,
  localparam int OFF_W = ADDR_W - BANK_BITS,
  localparam int IDX_W = $clog2(BANK_DEPTH)
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 ilv_i,
  output logic [BANK_BITS-1:0] bank_o,
  output logic [IDX_W-1:0]     idx_o
);
  split_mode_e      mode;
  logic [OFF_W-1:0] off;

  assign mode = split_mode_e'(ilv_i);

  always_comb begin
    if (mode == SPLIT_ILV) begin
      bank_o = addr_i[BANK_BITS-1:0];
      off    = addr_i[ADDR_W-1:BANK_BITS];
    end else begin
      bank_o = addr_i[ADDR_W-1:OFF_W];
      off    = addr_i[OFF_W-1:0];
    end
  end

  // reduced-depth banks alias on the low offset bits
  assign idx_o = IDX_W'(off % OFF_W'(BANK_DEPTH));
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder #(
  parameter int SEL_W = 3,
  localparam int NOUT = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NOUT-1:0]  cs_no
);
  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign cs_no[i] = ~(en_i && (sel_i == SEL_W'(i)));
  end
endmodule

// File: rtl/mem_bank.sv
module mem_bank #(
  parameter int DATA_W     = 8,
  parameter int BANK_DEPTH = 16,
  localparam int IDX_W = $clog2(BANK_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] mem [BANK_DEPTH];
  logic [DATA_W-1:0] q;
  logic              vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BANK_DEPTH; i++) mem[i] <= '0;
      q   <= '0;
      vld <= 1'b0;
    end else begin
      q   <= '0;
      vld <= 1'b0;
      if (!cs_ni) begin
        if (!we_ni) begin
          mem[idx_i] <= wdata_i;
        end else begin
          q   <= mem[idx_i];
          vld <= 1'b1;
        end
      end
    end
  end

  // deselected bank keeps bus at zero (models high impedance)
  assign rdata_o = q;
  assign drive_o = vld;

  AST_BANK_RD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> $past(!cs_ni && we_ni)) else $error("bank drove without read"); // R6
endmodule

// File: rtl/banked_mem_decoder.sv
module banked_mem_decoder #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int BANK_BITS  = 3,
  parameter int BANK_DEPTH = 16,
  localparam int NBANK = 1 << BANK_BITS,
  localparam int IDX_W = $clog2(BANK_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ilv_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NBANK-1:0]  cs_no,
  output logic              we_no,
  output logic              conflict_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              data_oe_o
);
  logic [BANK_BITS-1:0]         bank;
  logic [IDX_W-1:0]             idx;
  logic                         cmd_ok;
  logic [NBANK-1:0][DATA_W-1:0] bank_dout;
  logic [NBANK-1:0]             bank_drv;

  assign conflict_o = rd_i & wr_i;
  assign cmd_ok     = rd_i ^ wr_i;
  assign we_no      = ~(wr_i & ~rd_i);

  addr_split #(
    .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .BANK_DEPTH(BANK_DEPTH)
  ) u_split (
    .addr_i(addr_i), .ilv_i(ilv_i), .bank_o(bank), .idx_o(idx)
  );

  cs_decoder #(.SEL_W(BANK_BITS)) u_dec (
    .en_i(cmd_ok), .sel_i(bank), .cs_no(cs_no)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    mem_bank #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cs_ni(cs_no[b]), .we_ni(we_no),
      .idx_i(idx), .wdata_i(wdata_i),
      .rdata_o(bank_dout[b]), .drive_o(bank_drv[b])
    );
  end

  // wired-OR bus merge; idle banks present zero
  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) rdata_o = rdata_o | bank_dout[b];
  end

  assign rdata_vld_o = |bank_drv;
  assign data_oe_o   = |bank_drv;

  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> (&cs_no && we_no)) else $error("select while idle"); // R4
  AST_CONFLICT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |-> (&cs_no && we_no && conflict_o)) else $error("conflict not blocked"); // R7
  AST_SINGLE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i ^ wr_i) |-> ($countones(~cs_no) == 1)) else $error("not one select"); // R1
  AST_WE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (wr_i && !rd_i)) else $error("we without write"); // R5
  AST_BUS_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_drv)) else $error("bus contention"); // R8
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> rdata_vld_o) else $error("read data late"); // R6
endmodule

// File: tb/sim_banked_mem_decoder.sv
`timescale 1ns/1ps
module sim_banked_mem_decoder;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr_i = '0;
  logic        ilv_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  cs_no;
  logic        we_no, conflict_o, rdata_vld_o, data_oe_o;
  logic [7:0]  rdata_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [8][DEPTH];
  logic [7:0] exp_q [$];
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  banked_mem_decoder #(.BANK_DEPTH(DEPTH)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .ilv_i(ilv_i),
    .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .cs_no(cs_no),
    .we_no(we_no), .conflict_o(conflict_o), .rdata_o(rdata_o),
    .rdata_vld_o(rdata_vld_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [19:0] a, input bit ilv);
    return ilv ? int'(a[2:0]) : int'(a[19:17]);
  endfunction

  function automatic int idx_of(input logic [19:0] a, input bit ilv);
    return ilv ? int'(a[19:3]) % DEPTH : int'(a[16:0]) % DEPTH;
  endfunction

  task automatic do_write(input logic [19:0] a, input bit ilv, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; ilv_i = ilv; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    #1;
    chk(cs_no == ~(8'd1 << bank_of(a, ilv)), ilv ? "R2" : "R1", "write cs_no",
        cs_no, ~(8'd1 << bank_of(a, ilv)));
    chk(we_no == 1'b0, "R5", "we_no on write", we_no, 0);
    model[bank_of(a, ilv)][idx_of(a, ilv)] = d;
  endtask

  task automatic do_read(input logic [19:0] a, input bit ilv);
    @(negedge clk_i);
    addr_i = a; ilv_i = ilv; wr_i = 1'b0; rd_i = 1'b1;
    #1;
    chk(cs_no == ~(8'd1 << bank_of(a, ilv)), ilv ? "R2" : "R1", "read cs_no",
        cs_no, ~(8'd1 << bank_of(a, ilv)));
    chk(we_no == 1'b1, "R6", "we_no on read", we_no, 1);
    exp_q.push_back(model[bank_of(a, ilv)][idx_of(a, ilv)]);
  endtask

  task automatic do_idle();
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
    #1;
    chk(cs_no == 8'hFF && we_no == 1'b1, "R4", "idle cs_no/we_no", {we_no, cs_no}, 9'h1FF);
  endtask

  // monitor: one sample per cycle, 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && !done) begin
        chk(data_oe_o == rdata_vld_o, "R6", "oe tracks valid", data_oe_o, rdata_vld_o);
        if (rdata_vld_o) begin
          if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected read data", rdata_o, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rdata_o == e, "R6", "read data", rdata_o, e);
          end
        end else begin
          chk(rdata_o == 8'h00, "R6", "bus zero when idle", rdata_o, 0);
          if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            chk(1'b0, "R6", "read data missing", 0, 1);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < DEPTH; i++) model[b][i] = 8'h00;
    #12;
    chk(rdata_vld_o == 0 && data_oe_o == 0 && rdata_o == 0, "R9", "reset outputs",
        {rdata_vld_o, data_oe_o, rdata_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_idle();

    // R9: memory cleared by reset
    do_read(20'h60003, 1'b0);
    do_read(20'h00005, 1'b1);

    // R1: contiguous, each bank
    for (int b = 0; b < 8; b++) do_write({3'(b), 17'(b + 2)}, 1'b0, 8'(8'h10 + b));
    for (int b = 0; b < 8; b++) do_read({3'(b), 17'(b + 2)}, 1'b0);
    do_idle();

    // R8: same offset in bank 3 only
    do_write({3'd3, 17'd9}, 1'b0, 8'hA5);
    for (int b = 0; b < 8; b++) do_read({3'(b), 17'd9}, 1'b0);

    // R2: consecutive addresses walk the banks
    for (int a = 0; a < 16; a++) do_write(20'(a), 1'b1, 8'(8'h40 + a));
    for (int a = 0; a < 16; a++) do_read(20'(a), 1'b1);
    // cross-check: ilv addr 9 -> bank 1, offset 1 in contiguous view
    do_read({3'd1, 17'd1}, 1'b0);
    do_idle();

    // R3: offsets differing above the depth alias
    do_write({3'd5, 17'h00007}, 1'b0, 8'h3C);
    do_read({3'd5, 17'h10007}, 1'b0);
    do_write(20'h00C6, 1'b1, 8'h77);   // bank 6, offset 0x18 -> idx 8
    do_read(20'hF8046, 1'b1);          // bank 6, offset 0x1F008 -> idx 8
    do_idle();

    // R7: conflict blocks both
    @(negedge clk_i);
    addr_i = {3'd2, 17'd4}; ilv_i = 1'b0; wdata_i = 8'hEE; rd_i = 1'b1; wr_i = 1'b1;
    #1;
    chk(conflict_o == 1'b1, "R7", "conflict flag", conflict_o, 1);
    chk(cs_no == 8'hFF && we_no == 1'b1, "R7", "conflict deselect", {we_no, cs_no}, 9'h1FF);
    do_idle();
    chk(conflict_o == 1'b0, "R7", "conflict clears", conflict_o, 0);
    do_read({3'd2, 17'd4}, 1'b0);

    // mixed traffic
    for (int k = 0; k < 60; k++) begin
      logic [19:0] a;
      a = 20'($urandom);
      if (k % 3 == 0) do_read(a, k[0]);
      else do_write(a, k[0], 8'($urandom));
      if (k % 7 == 0) do_idle();
    end
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < DEPTH; i++) do_read({3'(b), 17'(i)}, 1'b0);
    do_idle();
    do_idle();
    chk(exp_q.size() == 0, "R6", "all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule